// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the central state machine of a 32-bit load/store processor whose datapath reuses one ALU and one memory port across several clock cycles for each instruction. Each cycle it reads the opcode held in the instruction register and produces the datapath steering and write-enable strobes for that cycle. The strobes are Moore outputs, so they depend only on the present state. Every instruction begins with a shared fetch cycle and a shared decode cycle. The decode cycle then branches into a separate path for each instruction class.

Five instruction classes are handled: register-register ALU operations, word load, word store, branch-if-equal, and an indexed load. The indexed load adds two registers to form the address and writes the loaded word to the register named in the destination (rd) field. It has its own three-state path after decode. Any other opcode ends the instruction right after decode, and no register, memory or branch write takes place.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset forces the fetch state from the next clock edge, including when the reset arrives in the middle of an instruction.
- R2: Fetch drives pc_wr=1, mem_rd=1, ir_wr=1, addr_sel=0, alu_a_sel=0, alu_b_sel=01, alu_op=00, with every other strobe 0. The state after fetch is always decode.
- R3: Decode drives alu_a_sel=0, alu_b_sel=11 and alu_op=00, with every other strobe 0. It dispatches on the 6-bit opcode: 000000 register-register, 100011 load, 101011 store, 000100 branch, 110011 indexed load.
- R4: A register-register instruction takes 4 cycles. Its third cycle drives alu_a_sel=1, alu_b_sel=00, alu_op=10. Its fourth cycle drives rf_wr=1, dst_sel=1, wb_sel=0.
- R5: A load takes 5 cycles. Its third cycle is an address add (alu_a_sel=1, alu_b_sel=10, alu_op=00). Its fourth cycle is a read (mem_rd=1, addr_sel=1). Its fifth cycle writes back (rf_wr=1, wb_sel=1, dst_sel=0).
- R6: A store takes 4 cycles. It uses the same address-add cycle as a load, followed by a write cycle with mem_wr=1 and addr_sel=1.
- R7: A branch takes 3 cycles. Its third cycle drives pc_wr_cond=1, pc_src=1, alu_a_sel=1, alu_b_sel=00, alu_op=01.
- R8: An indexed load takes 5 cycles. The third cycle drives alu_a_sel=1, alu_b_sel=00, alu_op=00. The fourth drives mem_rd=1, addr_sel=1. The fifth drives rf_wr=1, dst_sel=1, wb_sel=1. The machine then returns to fetch.
- R9: An unrecognised opcode returns the machine from decode to fetch. No rf_wr, mem_wr or pc_wr_cond is raised for it.
- R10: Outputs depend only on the current state. Changing opcode or funct within a cycle does not change them, and funct has no effect on any sequence.
- R11: mem_rd and mem_wr are never both high. At most one of pc_wr, rf_wr and mem_wr is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| funct_i | input | 6 | Function field of the instruction register (consumed by the ALU control downstream) |
| pc_wr_o | output | 1 | Unconditional PC write |
| pc_wr_cond_o | output | 1 | PC write when the ALU reports equality |
| addr_sel_o | output | 1 | Memory address source: 0 PC, 1 ALU result register |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| ir_wr_o | output | 1 | Instruction register load |
| wb_sel_o | output | 1 | Register write data: 0 ALU result, 1 memory data register |
| dst_sel_o | output | 1 | Destination register: 0 rt field, 1 rd field |
| rf_wr_o | output | 1 | Register file write |
| alu_a_sel_o | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel_o | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_op_o | output | 2 | ALU operation: 00 add, 01 subtract, 10 from funct |
| pc_src_o | output | 1 | PC source: 0 ALU output, 1 ALU result register |

## Verification
The embedded properties watch every cycle for the following. Fetch must be followed by decode. The indexed-load, load and store paths must keep their order and length. The machine must leave decode on an unknown opcode. The opcode matches must never overlap. A conditional PC write may only follow a branch decode, and a register write may only follow an execute or read cycle. The memory and write strobes must stay mutually exclusive. The exact strobe values of each state, the full cycle counts of each class, reset in the middle of an instruction, and the lack of any effect from the function field and from opcode changes within a state can only be shown by the directed scenarios that walk each instruction cycle by cycle.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OPW         = 6;
    localparam int FNW         = 6;
    localparam int NUM_CLASSES = 5;

    typedef enum logic [3:0] {
        ST_FETCH    = 4'd0,
        ST_DECODE   = 4'd1,
        ST_R_EXEC   = 4'd2,
        ST_R_WB     = 4'd3,
        ST_MEM_ADDR = 4'd4,
        ST_LD_READ  = 4'd5,
        ST_LD_WB    = 4'd6,
        ST_ST_WRITE = 4'd7,
        ST_BR_CMP   = 4'd8,
        ST_IX_ADDR  = 4'd9,
        ST_IX_READ  = 4'd10,
        ST_IX_WB    = 4'd11
    } ctrl_state_e;

    // Class index order matches the opcode list in the decoder.
    typedef enum logic [2:0] {
        IC_RTYPE  = 3'd0,
        IC_LOAD   = 3'd1,
        IC_STORE  = 3'd2,
        IC_BRANCH = 3'd3,
        IC_IXLOAD = 3'd4,
        IC_NONE   = 3'd7
    } instr_class_e;

    typedef enum logic [1:0] {
        ASB_REG   = 2'b00,
        ASB_FOUR  = 2'b01,
        ASB_IMM   = 2'b10,
        ASB_BROFF = 2'b11
    } alu_b_sel_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } alu_op_e;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       wb_sel;
        logic       dst_sel;
        logic       rf_wr;
        logic       alu_a_sel;
        alu_b_sel_e alu_b_sel;
        alu_op_e    alu_op;
        logic       pc_src;
    } ctrl_word_t;

    function automatic ctrl_word_t ctrl_idle();
        ctrl_word_t w;
        w.pc_wr      = 1'b0;
        w.pc_wr_cond = 1'b0;
        w.addr_sel   = 1'b0;
        w.mem_rd     = 1'b0;
        w.mem_wr     = 1'b0;
        w.ir_wr      = 1'b0;
        w.wb_sel     = 1'b0;
        w.dst_sel    = 1'b0;
        w.rf_wr      = 1'b0;
        w.alu_a_sel  = 1'b0;
        w.alu_b_sel  = ASB_REG;
        w.alu_op     = AOP_ADD;
        w.pc_src     = 1'b0;
        return w;
    endfunction

    function automatic logic is_writeback_src(ctrl_state_e s);
        return (s == ST_R_EXEC) || (s == ST_LD_READ) || (s == ST_IX_READ);
    endfunction

endpackage

// File: rtl/mc_op_decode.sv
module mc_op_decode
    import mc_ctrl_pkg::*;
#(
    parameter logic [OPW-1:0] OPC_RTYPE  = 6'b000000,
    parameter logic [OPW-1:0] OPC_LOAD   = 6'b100011,
    parameter logic [OPW-1:0] OPC_STORE  = 6'b101011,
    parameter logic [OPW-1:0] OPC_BRANCH = 6'b000100,
    parameter logic [OPW-1:0] OPC_IXLOAD = 6'b110011
) (
    input  logic [OPW-1:0]         opcode_i,
    output logic [NUM_CLASSES-1:0] hit_o,
    output instr_class_e           cls_o
);

    localparam logic [OPW-1:0] OPC_LIST [NUM_CLASSES] =
        '{OPC_RTYPE, OPC_LOAD, OPC_STORE, OPC_BRANCH, OPC_IXLOAD};

    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_match
        assign hit_o[g] = (opcode_i == OPC_LIST[g]);
    end

    // Lowest class index wins should two parameters ever collide.
    always_comb begin
        cls_o = IC_NONE;
        for (int i = NUM_CLASSES - 1; i >= 0; i--) begin
            if (hit_o[i]) begin
                cls_o = instr_class_e'(i[2:0]);
            end
        end
    end

endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
    import mc_ctrl_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  instr_class_e cls_i,
    output ctrl_state_e  state_o
);

    ctrl_state_e state_q;
    ctrl_state_e state_d;

    always_comb begin
        state_d = ST_FETCH;
        unique case (state_q)
            ST_FETCH:    state_d = ST_DECODE;
            ST_DECODE: begin
                case (cls_i)
                    IC_RTYPE:           state_d = ST_R_EXEC;
                    IC_LOAD, IC_STORE:  state_d = ST_MEM_ADDR;
                    IC_BRANCH:          state_d = ST_BR_CMP;
                    IC_IXLOAD:          state_d = ST_IX_ADDR;
                    default:            state_d = ST_FETCH;
                endcase
            end
            ST_R_EXEC:   state_d = ST_R_WB;
            ST_R_WB:     state_d = ST_FETCH;
            ST_MEM_ADDR: begin
                case (cls_i)
                    IC_LOAD:  state_d = ST_LD_READ;
                    IC_STORE: state_d = ST_ST_WRITE;
                    default:  state_d = ST_FETCH;
                endcase
            end
            ST_LD_READ:  state_d = ST_LD_WB;
            ST_LD_WB:    state_d = ST_FETCH;
            ST_ST_WRITE: state_d = ST_FETCH;
            ST_BR_CMP:   state_d = ST_FETCH;
            ST_IX_ADDR:  state_d = ST_IX_READ;
            ST_IX_READ:  state_d = ST_IX_WB;
            ST_IX_WB:    state_d = ST_FETCH;
            default:     state_d = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    AST_RESET_TO_FETCH: assert property (@(posedge clk) rst |=> (state_q == ST_FETCH)); // R1
    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE)); // R2
    AST_BAD_OP_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DECODE && cls_i == IC_NONE) |=> (state_q == ST_FETCH)); // R9
    AST_LOAD_READ_TO_WB: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LD_READ) |=> (state_q == ST_LD_WB)); // R5
    AST_STORE_ENDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ST_WRITE) |=> (state_q == ST_FETCH)); // R6
    AST_IX_ADDR_TO_READ: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IX_ADDR) |=> (state_q == ST_IX_READ)); // R8
    AST_IX_READ_TO_WB: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IX_READ) |=> (state_q == ST_IX_WB)); // R8
    AST_IX_WB_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IX_WB) |=> (state_q == ST_FETCH)); // R8

endmodule

// File: rtl/mc_ctrl_outputs.sv
module mc_ctrl_outputs
    import mc_ctrl_pkg::*;
(
    input  ctrl_state_e state_i,
    output ctrl_word_t  ctrl_o
);

    always_comb begin
        ctrl_o = ctrl_idle();
        unique case (state_i)
            ST_FETCH: begin
                ctrl_o.mem_rd    = 1'b1;
                ctrl_o.ir_wr     = 1'b1;
                ctrl_o.pc_wr     = 1'b1;
                ctrl_o.alu_b_sel = ASB_FOUR;
            end
            ST_DECODE: begin
                ctrl_o.alu_b_sel = ASB_BROFF;
            end
            ST_R_EXEC: begin
                ctrl_o.alu_a_sel = 1'b1;
                ctrl_o.alu_op    = AOP_FUNCT;
            end
            ST_R_WB: begin
                ctrl_o.rf_wr   = 1'b1;
                ctrl_o.dst_sel = 1'b1;
            end
            ST_MEM_ADDR: begin
                ctrl_o.alu_a_sel = 1'b1;
                ctrl_o.alu_b_sel = ASB_IMM;
            end
            ST_LD_READ, ST_IX_READ: begin
                ctrl_o.mem_rd   = 1'b1;
                ctrl_o.addr_sel = 1'b1;
            end
            ST_LD_WB: begin
                ctrl_o.rf_wr  = 1'b1;
                ctrl_o.wb_sel = 1'b1;
            end
            ST_ST_WRITE: begin
                ctrl_o.mem_wr   = 1'b1;
                ctrl_o.addr_sel = 1'b1;
            end
            ST_BR_CMP: begin
                ctrl_o.alu_a_sel  = 1'b1;
                ctrl_o.alu_op     = AOP_SUB;
                ctrl_o.pc_wr_cond = 1'b1;
                ctrl_o.pc_src     = 1'b1;
            end
            ST_IX_ADDR: begin
                ctrl_o.alu_a_sel = 1'b1;
            end
            ST_IX_WB: begin
                ctrl_o.rf_wr   = 1'b1;
                ctrl_o.dst_sel = 1'b1;
                ctrl_o.wb_sel  = 1'b1;
            end
            default: ctrl_o = ctrl_idle();
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter logic [OPW-1:0] OPC_RTYPE  = 6'b000000,
    parameter logic [OPW-1:0] OPC_LOAD   = 6'b100011,
    parameter logic [OPW-1:0] OPC_STORE  = 6'b101011,
    parameter logic [OPW-1:0] OPC_BRANCH = 6'b000100,
    parameter logic [OPW-1:0] OPC_IXLOAD = 6'b110011
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode_i,
    input  logic [FNW-1:0] funct_i,
    output logic           pc_wr_o,
    output logic           pc_wr_cond_o,
    output logic           addr_sel_o,
    output logic           mem_rd_o,
    output logic           mem_wr_o,
    output logic           ir_wr_o,
    output logic           wb_sel_o,
    output logic           dst_sel_o,
    output logic           rf_wr_o,
    output logic           alu_a_sel_o,
    output logic [1:0]     alu_b_sel_o,
    output logic [1:0]     alu_op_o,
    output logic           pc_src_o
);

    logic [NUM_CLASSES-1:0] op_hit;
    instr_class_e           op_cls;
    ctrl_state_e            state;
    ctrl_word_t             ctrl;

    // The function field is consumed by the ALU control stage, not here.
    logic funct_unused;
    assign funct_unused = ^funct_i;

    mc_op_decode #(
        .OPC_RTYPE  (OPC_RTYPE),
        .OPC_LOAD   (OPC_LOAD),
        .OPC_STORE  (OPC_STORE),
        .OPC_BRANCH (OPC_BRANCH),
        .OPC_IXLOAD (OPC_IXLOAD)
    ) u_op_decode (
        .opcode_i (opcode_i),
        .hit_o    (op_hit),
        .cls_o    (op_cls)
    );

    mc_ctrl_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .cls_i   (op_cls),
        .state_o (state)
    );

    mc_ctrl_outputs u_outputs (
        .state_i (state),
        .ctrl_o  (ctrl)
    );

    assign pc_wr_o      = ctrl.pc_wr;
    assign pc_wr_cond_o = ctrl.pc_wr_cond;
    assign addr_sel_o   = ctrl.addr_sel;
    assign mem_rd_o     = ctrl.mem_rd;
    assign mem_wr_o     = ctrl.mem_wr;
    assign ir_wr_o      = ctrl.ir_wr;
    assign wb_sel_o     = ctrl.wb_sel;
    assign dst_sel_o    = ctrl.dst_sel;
    assign rf_wr_o      = ctrl.rf_wr;
    assign alu_a_sel_o  = ctrl.alu_a_sel;
    assign alu_b_sel_o  = ctrl.alu_b_sel;
    assign alu_op_o     = ctrl.alu_op;
    assign pc_src_o     = ctrl.pc_src;

    AST_OPC_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(op_hit)); // R3
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o)); // R11
    AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (rst)
        $countones({pc_wr_o, rf_wr_o, mem_wr_o}) <= 1); // R11
    AST_BRANCH_AFTER_DECODE: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond_o |-> ($past(state) == ST_DECODE && $past(op_cls) == IC_BRANCH)); // R7
    AST_RF_WR_SOURCE: assert property (@(posedge clk) disable iff (rst)
        rf_wr_o |-> is_writeback_src($past(state))); // R4

endmodule

// File: tb/mc_ctrl_fsm_tb.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] opcode;
    logic [5:0] funct;
    logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr;
    logic       wb_sel, dst_sel, rf_wr, alu_a_sel, pc_src;
    logic [1:0] alu_b_sel, alu_op;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mc_ctrl_fsm u_dut (
        .clk          (clk),
        .rst          (rst),
        .opcode_i     (opcode),
        .funct_i      (funct),
        .pc_wr_o      (pc_wr),
        .pc_wr_cond_o (pc_wr_cond),
        .addr_sel_o   (addr_sel),
        .mem_rd_o     (mem_rd),
        .mem_wr_o     (mem_wr),
        .ir_wr_o      (ir_wr),
        .wb_sel_o     (wb_sel),
        .dst_sel_o    (dst_sel),
        .rf_wr_o      (rf_wr),
        .alu_a_sel_o  (alu_a_sel),
        .alu_b_sel_o  (alu_b_sel),
        .alu_op_o     (alu_op),
        .pc_src_o     (pc_src)
    );

    // Bit order: pc_wr pc_wr_cond addr_sel mem_rd mem_wr ir_wr wb_sel dst_sel rf_wr alu_a alu_b[2] alu_op[2] pc_src
    localparam logic [14:0] V_FETCH  = 15'b1_0_0_1_0_1_0_0_0_0_01_00_0;
    localparam logic [14:0] V_DECODE = 15'b0_0_0_0_0_0_0_0_0_0_11_00_0;
    localparam logic [14:0] V_REXEC  = 15'b0_0_0_0_0_0_0_0_0_1_00_10_0;
    localparam logic [14:0] V_RWB    = 15'b0_0_0_0_0_0_0_1_1_0_00_00_0;
    localparam logic [14:0] V_MADDR  = 15'b0_0_0_0_0_0_0_0_0_1_10_00_0;
    localparam logic [14:0] V_MREAD  = 15'b0_0_1_1_0_0_0_0_0_0_00_00_0;
    localparam logic [14:0] V_LDWB   = 15'b0_0_0_0_0_0_1_0_1_0_00_00_0;
    localparam logic [14:0] V_STWR   = 15'b0_0_1_0_1_0_0_0_0_0_00_00_0;
    localparam logic [14:0] V_BRCMP  = 15'b0_1_0_0_0_0_0_0_0_1_00_01_1;
    localparam logic [14:0] V_IXADDR = 15'b0_0_0_0_0_0_0_0_0_1_00_00_0;
    localparam logic [14:0] V_IXWB   = 15'b0_0_0_0_0_0_1_1_1_0_00_00_0;

    function automatic logic [14:0] observed();
        return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr,
                wb_sel, dst_sel, rf_wr, alu_a_sel, alu_b_sel, alu_op, pc_src};
    endfunction

    task automatic check(input logic [14:0] exp, input string req, input string what);
        logic [14:0] got;
        got = observed();
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    // Entered at a falling edge with the DUT in fetch; leaves it in fetch again.
    task automatic run_seq(input logic [5:0] opc, input logic [5:0] fn, input string req,
                           input int n, input logic [14:0] seq [5]);
        opcode = opc;
        funct  = fn;
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge clk);
            check(seq[i], req, $sformatf("cycle %0d", i));
        end
        @(negedge clk);
        check(V_FETCH, req, "return to fetch");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        opcode = 6'b000000;
        funct = 6'b000000;
        repeat (3) @(negedge clk);
        check(V_FETCH, "R1", "state during reset");
        rst = 1'b0;
    endtask

    task automatic t_rtype(input logic [5:0] fn);
        logic [14:0] s [5] = '{V_FETCH, V_DECODE, V_REXEC, V_RWB, 15'b0};
        run_seq(6'b000000, fn, "R4", 4, s);
    endtask

    task automatic t_load();
        logic [14:0] s [5] = '{V_FETCH, V_DECODE, V_MADDR, V_MREAD, V_LDWB};
        run_seq(6'b100011, 6'b000000, "R5", 5, s);
    endtask

    task automatic t_store();
        logic [14:0] s [5] = '{V_FETCH, V_DECODE, V_MADDR, V_STWR, 15'b0};
        run_seq(6'b101011, 6'b000000, "R6", 4, s);
    endtask

    task automatic t_branch();
        logic [14:0] s [5] = '{V_FETCH, V_DECODE, V_BRCMP, 15'b0, 15'b0};
        run_seq(6'b000100, 6'b000000, "R7", 3, s);
    endtask

    task automatic t_ixload();
        logic [14:0] s [5] = '{V_FETCH, V_DECODE, V_IXADDR, V_MREAD, V_IXWB};
        run_seq(6'b110011, 6'b100101, "R8", 5, s);
    endtask

    task automatic t_unknown(input logic [5:0] opc);
        logic [14:0] s [5] = '{V_FETCH, V_DECODE, 15'b0, 15'b0, 15'b0};
        run_seq(opc, 6'b000000, "R9", 2, s);
    endtask

    // R3: decode strobes plus dispatch, R10: opcode and funct wiggle within a state
    task automatic t_moore();
        opcode = 6'b000000;
        funct  = 6'b100000;
        check(V_FETCH, "R2", "fetch strobes");
        @(negedge clk);
        check(V_DECODE, "R3", "decode strobes");
        @(negedge clk);
        check(V_REXEC, "R10", "exec before wiggle");
        opcode = 6'b101011;
        funct  = 6'b111111;
        #1;
        check(V_REXEC, "R10", "exec after opcode/funct wiggle");
        opcode = 6'b000000;
        @(negedge clk);
        check(V_RWB, "R10", "writeback after wiggle");
        @(negedge clk);
        check(V_FETCH, "R10", "return to fetch");
    endtask

    // R1: reset in the middle of a load
    task automatic t_mid_reset();
        opcode = 6'b100011;
        check(V_FETCH, "R1", "load fetch");
        @(negedge clk);
        @(negedge clk);
        check(V_MADDR, "R1", "load address add before reset");
        rst = 1'b1;
        @(negedge clk);
        check(V_FETCH, "R1", "fetch after mid reset");
        @(negedge clk);
        check(V_FETCH, "R1", "fetch held in reset");
        rst = 1'b0;
        opcode = 6'b000000;
        @(negedge clk);
        check(V_DECODE, "R2", "decode after reset release");
        @(negedge clk);
        check(V_REXEC, "R4", "exec after reset release");
        @(negedge clk);
        @(negedge clk);
        check(V_FETCH, "R4", "back to fetch");
    endtask

    initial begin
        t_reset();
        t_rtype(6'b100000);
        t_rtype(6'b100010);
        t_load();
        t_store();
        t_branch();
        t_ixload();
        t_unknown(6'b111111);
        t_unknown(6'b000010);
        t_ixload();
        t_load();
        t_moore();
        t_mid_reset();
        t_store();
        t_branch();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule